// File: doc/BRIEF.md
# Transmit Amplitude Fine Scaler

This block applies a small gain correction to a signed transmit sample stream just before it leaves the modulator datapath. The correction is a 3-bit sign-and-magnitude trim. Its magnitude `c` (0 to 3) sets a step of `c/16` away from unity, and its sign bit decides whether that step is added or subtracted. Two trims are held at the ports, one for the 1 Mbps data rate and one for the 2 Mbps data rate. A rate-select input picks which of them applies.

A trim-enable input turns the correction on. When it is clear, samples pass through at unity gain. A force input replaces the scaled sample with a raw 8-bit value taken from a port. This lets a fixed level be driven regardless of the filter output. The arithmetic uses shifts and adds only, and the result saturates to the sample range. One register stage sits between the sample input and the output.

Top module: `txs_fine_scaler`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0 and `out_sample` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock.
- R3: With `force_en`=0 and `trim_en`=0, an accepted sample appears unchanged on `out_sample` one clock later.
- R4: With the selected trim's bit 2 = 1 (boost), the output is `x + floor(x*c/16)`, where `c` is trim bits [1:0]. The result is then saturated as in R7.
- R5: With the selected trim's bit 2 = 0 (cut), the output is `x - floor(x*c/16)`, where `c` is trim bits [1:0].
- R6: `rate_2m`=0 selects `trim_1m`, and `rate_2m`=1 selects `trim_2m`. The trim that is not selected has no effect on the output.
- R7: The trimmed result saturates to the range [-2^(DW-1), 2^(DW-1)-1] and never wraps.
- R8: With `force_en`=1, an accepted sample produces `out_sample` = `force_val`, whatever the sample, trims or `trim_en`. For DW=8 this is a bit-for-bit copy.
- R9: With a selected trim magnitude of 0, the output equals the input for both values of the sign bit.
- R10: While `in_valid` is 0, `out_sample` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | DW | Signed input sample |
| rate_2m | input | 1 | 0: 1 Mbps trim, 1: 2 Mbps trim |
| trim_en | input | 1 | Enables the gain trim |
| trim_1m | input | 3 | Trim for 1 Mbps: bit 2 sign (1 boost), bits [1:0] magnitude |
| trim_2m | input | 3 | Trim for 2 Mbps, same encoding |
| force_en | input | 1 | Selects the raw force value as output |
| force_val | input | 8 | Raw output value used when forcing |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | DW | Registered, saturated output sample |

## Verification
Every result is due exactly one clock after the edge that accepts the sample: the valid flag, the trimmed value, the forced value and the held value. The bench drives each stimulus on a falling edge. It compares the outputs on the next falling edge against a model that runs on bench integers. The model holds its previous sample whenever the valid input was low. Random samples and trims are mixed with directed extremes at both range limits.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int COEF_W     = 3;
    localparam int MAG_W      = 2;
    localparam int FRAC_SHIFT = 4;
    localparam int FORCE_W    = 8;
    localparam int GROW_W     = 3;

    typedef struct packed {
        logic              boost;
        logic [MAG_W-1:0]  mag;
    } trim_t;

    typedef enum logic {
        RATE_1M = 1'b0,
        RATE_2M = 1'b1
    } rate_e;

    typedef enum logic {
        SRC_TRIM  = 1'b0,
        SRC_FORCE = 1'b1
    } src_e;

    function automatic trim_t to_trim(input logic [COEF_W-1:0] raw);
        trim_t t;
        t.boost = raw[COEF_W-1];
        t.mag   = raw[MAG_W-1:0];
        return t;
    endfunction

endpackage

// File: rtl/txs_trim_sel.sv
module txs_trim_sel
    import txs_pkg::*;
(
    input  logic               rate_2m,
    input  logic               trim_en,
    input  logic [COEF_W-1:0]  trim_1m,
    input  logic [COEF_W-1:0]  trim_2m,
    output trim_t              trim_eff
);
    rate_e rate;
    trim_t picked;

    always_comb begin
        rate   = rate_e'(rate_2m);
        picked = (rate == RATE_2M) ? to_trim(trim_2m) : to_trim(trim_1m);
        trim_eff = picked;
        if (!trim_en) begin
            trim_eff.mag = '0;
        end
    end
endmodule

// File: rtl/txs_trim_arith.sv
module txs_trim_arith
    import txs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic signed [DW-1:0]        x,
    input  trim_t                        trim,
    output logic signed [DW+GROW_W-1:0] y
);
    localparam int EW = DW + GROW_W;

    logic signed [EW-1:0] xe;
    logic signed [EW-1:0] term [MAG_W];
    logic signed [EW-1:0] prod;
    logic signed [EW-1:0] delta;

    assign xe = EW'(x);

    for (genvar b = 0; b < MAG_W; b++) begin : g_term
        assign term[b] = trim.mag[b] ? (xe <<< b) : EW'(0);
    end

    always_comb begin
        prod = '0;
        for (int b = 0; b < MAG_W; b++) begin
            prod = prod + term[b];
        end
        delta = prod >>> FRAC_SHIFT;
        y     = trim.boost ? (xe + delta) : (xe - delta);
    end
endmodule

// File: rtl/txs_sat_mux.sv
module txs_sat_mux
    import txs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic signed [DW+GROW_W-1:0] wide,
    input  logic                         force_en,
    input  logic [FORCE_W-1:0]           force_val,
    output logic signed [DW-1:0]         result
);
    localparam int EW = DW + GROW_W;
    localparam logic signed [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

    logic              fits;
    logic signed [DW-1:0] clipped;
    logic [DW-1:0]     forced;
    src_e              src;

    // fits when every bit above the output sign bit copies it
    assign fits = (wide[EW-1:DW-1] == {(GROW_W+1){wide[EW-1]}});

    always_comb begin
        if (fits) begin
            clipped = wide[DW-1:0];
        end else if (wide[EW-1]) begin
            clipped = NEG_MIN;
        end else begin
            clipped = POS_MAX;
        end
    end

    if (DW > FORCE_W) begin : g_force_wide
        assign forced = {{(DW-FORCE_W){force_val[FORCE_W-1]}}, force_val};
    end else if (DW == FORCE_W) begin : g_force_eq
        assign forced = force_val;
    end else begin : g_force_narrow
        assign forced = force_val[DW-1:0];
    end

    assign src    = src_e'(force_en);
    assign result = (src == SRC_FORCE) ? $signed(forced) : clipped;
endmodule

// File: rtl/txs_fine_scaler.sv
module txs_fine_scaler
    import txs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic signed [DW-1:0]  in_sample,
    input  logic                  rate_2m,
    input  logic                  trim_en,
    input  logic [COEF_W-1:0]     trim_1m,
    input  logic [COEF_W-1:0]     trim_2m,
    input  logic                  force_en,
    input  logic [FORCE_W-1:0]    force_val,
    output logic                  out_valid,
    output logic signed [DW-1:0]  out_sample
);
    localparam int EW = DW + GROW_W;

    trim_t                 trim_eff;
    logic signed [EW-1:0]  wide;
    logic signed [DW-1:0]  next_sample;

    txs_trim_sel u_sel (
        .rate_2m  (rate_2m),
        .trim_en  (trim_en),
        .trim_1m  (trim_1m),
        .trim_2m  (trim_2m),
        .trim_eff (trim_eff)
    );

    txs_trim_arith #(.DW(DW)) u_arith (
        .x    (in_sample),
        .trim (trim_eff),
        .y    (wide)
    );

    txs_sat_mux #(.DW(DW)) u_sat (
        .wide      (wide),
        .force_en  (force_en),
        .force_val (force_val),
        .result    (next_sample)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= next_sample;
            end
        end
    end
endmodule

// File: rtl/txs_fine_scaler_chk.sv
module txs_fine_scaler_chk
    import txs_pkg::*;
#(
    parameter int DW = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic signed [DW-1:0]  in_sample,
    input logic                  rate_2m,
    input logic                  trim_en,
    input logic [COEF_W-1:0]     trim_1m,
    input logic [COEF_W-1:0]     trim_2m,
    input logic                  force_en,
    input logic [FORCE_W-1:0]    force_val,
    input logic                  out_valid,
    input logic signed [DW-1:0]  out_sample
);
    localparam int LW = (DW < FORCE_W) ? DW : FORCE_W;

    logic [COEF_W-1:0] sel_raw;
    assign sel_raw = rate_2m ? trim_2m : trim_1m;

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !force_en && !trim_en) |=> (out_sample == $past(in_sample)));

    assert_unity_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !force_en && (sel_raw[1:0] == 2'b00)) |=> (out_sample == $past(in_sample)));

    assert_force_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && force_en) |=> (out_sample[LW-1:0] == $past(force_val[LW-1:0])));

    assert_boost_grows_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !force_en && sel_raw[2] && !in_sample[DW-1])
        |=> (out_sample >= $past(in_sample)));

    assert_cut_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !force_en && !sel_raw[2] && !in_sample[DW-1])
        |=> (out_sample <= $past(in_sample)));
endmodule

bind txs_fine_scaler txs_fine_scaler_chk #(.DW(DW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .rate_2m    (rate_2m),
    .trim_en    (trim_en),
    .trim_1m    (trim_1m),
    .trim_2m    (trim_2m),
    .force_en   (force_en),
    .force_val  (force_val),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/txs_fine_scaler_tb_top.sv
module txs_fine_scaler_tb_top;
    localparam int DW = 8;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic signed [DW-1:0] in_sample;
    logic                 rate_2m;
    logic                 trim_en;
    logic [2:0]           trim_1m;
    logic [2:0]           trim_2m;
    logic                 force_en;
    logic [7:0]           force_val;
    logic                 out_valid;
    logic signed [DW-1:0] out_sample;

    int checks = 0;
    int errors = 0;
    int model_out = 0;
    int exp_valid = 0;
    string exp_tag = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    txs_fine_scaler #(.DW(DW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .rate_2m(rate_2m), .trim_en(trim_en), .trim_1m(trim_1m), .trim_2m(trim_2m),
        .force_en(force_en), .force_val(force_val),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int sat(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int trim_ref(input int x, input bit en, input bit [2:0] t);
        int c;
        int d;
        c = en ? int'(t[1:0]) : 0;
        d = (x * c) >>> 4;
        return t[2] ? sat(x + d) : sat(x - d);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one stimulus on a falling edge, check it on the next falling edge
    task automatic step(input bit v, input int x, input bit r, input bit en,
                        input bit [2:0] t1, input bit [2:0] t2,
                        input bit f, input bit [7:0] fv);
        bit [2:0] t;
        int raw;
        in_valid  = v;
        in_sample = DW'(x);
        rate_2m   = r;
        trim_en   = en;
        trim_1m   = t1;
        trim_2m   = t2;
        force_en  = f;
        force_val = fv;
        t = r ? t2 : t1;
        if (v) begin
            if (f) begin
                model_out = int'($signed(fv));
                exp_tag = "R8";
            end else begin
                model_out = trim_ref(x, en, t);
                raw = en ? (t[2] ? x + ((x * int'(t[1:0])) >>> 4)
                                 : x - ((x * int'(t[1:0])) >>> 4)) : x;
                if (!en) exp_tag = "R3";
                else if (raw != model_out) exp_tag = "R7";
                else if (t[1:0] == 2'b00) exp_tag = "R9";
                else if (t[2]) exp_tag = "R4";
                else exp_tag = "R5";
            end
        end else begin
            exp_tag = "R10";
        end
        exp_valid = v;
        @(negedge clk);
        check("R2", int'(out_valid), exp_valid);
        check(exp_tag, int'(out_sample), model_out);
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        in_valid = 1'b1; in_sample = 8'sd77; rate_2m = 1'b0; trim_en = 1'b1;
        trim_1m = 3'b111; trim_2m = 3'b111; force_en = 1'b0; force_val = 8'h00;
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_sample), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_sample), 0);
        model_out = 0;

        // directed corner cases
        step(1, 127, 0, 1, 3'b111, 3'b000, 0, 8'h00);   // R7 positive clip
        step(1, -128, 0, 1, 3'b111, 3'b000, 0, 8'h00);  // R7 negative clip
        step(1, -128, 1, 1, 3'b000, 3'b011, 0, 8'h00);  // R5 cut, -104
        step(1, 100, 0, 1, 3'b100, 3'b000, 0, 8'h00);   // R9 boost sign, c=0
        step(1, 100, 0, 1, 3'b000, 3'b111, 0, 8'h00);   // R9 cut sign, c=0
        step(1, 64, 0, 0, 3'b111, 3'b111, 0, 8'h00);    // R3 bypass
        step(1, -5, 0, 1, 3'b001, 3'b000, 0, 8'h00);    // R5 floor on negative
        step(1, 5, 1, 1, 3'b000, 3'b111, 0, 8'hA5);     // R8 off, R4
        step(1, 33, 1, 1, 3'b000, 3'b111, 1, 8'hA5);    // R8 force
        step(0, 99, 0, 1, 3'b111, 3'b111, 1, 8'h11);    // R10 hold
        step(0, -99, 1, 0, 3'b000, 3'b000, 0, 8'h22);   // R10 hold

        // R6: same sample, trims differ per rate
        step(1, 80, 0, 1, 3'b111, 3'b011, 0, 8'h00);
        check("R6", int'(out_sample), 95);
        step(1, 80, 1, 1, 3'b111, 3'b011, 0, 8'h00);
        check("R6", int'(out_sample), 65);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 8) != 0,
                 int'($signed(8'($urandom))),
                 1'($urandom), ($urandom % 5) != 0,
                 3'($urandom), 3'($urandom),
                 ($urandom % 10) == 0, 8'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule